// File: doc/BRIEF.md
# Wide Microcode Store with Indirect Register Window

This block keeps a small bank of microcode words, each wider than the register bus, and lets a 32-bit register port load and inspect them through two registers. A select register names a slot and a 32-bit lane inside that slot. A data register then writes or reads that lane. A separate fetch port, used by an execution engine, delivers a whole word by slot number one cycle after it is requested.

The default word is 257 bits. That is eight full lanes plus one lane that holds a single bit. The window clips that last lane. Lane numbers past the end of the word are dead: writes to them change nothing and reads from them return zero. Register reads are registered. The read value appears on the cycle after the read strobe and stays until the next read.

Top module: `ucode_window`

## Requirements
- R1: After reset, the select register is zero, every stored word is zero, `reg_rdata` is zero and `fetch_word` is zero.
- R2: A write with `reg_addr`=0 loads the select register from `reg_wdata[6:0]`. The slot number is bits [2:0] and the lane number is bits [6:3]. Reading `reg_addr`=0 returns those 7 bits, with bits [31:7] read as zero.
- R3: A write with `reg_addr`=1 while the lane is 0 to 7 replaces bits [32k+31:32k] of the selected slot, where k is the lane. All other bits in the store stay as they were.
- R4: A data write to lane 8 sets only bit 256 of the selected slot, taking it from `reg_wdata[0]`. A data read from lane 8 returns bit 256 in bit 0, with the upper bits zero.
- R5: A data write to any lane from 9 to 15 leaves the store unchanged. A data read from those lanes returns zero.
- R6: A data read from lanes 0 to 7 returns bits [32k+31:32k] of the selected slot.
- R7: `reg_rdata` takes its new value on the clock edge that samples `reg_rd`. It is visible in the next cycle and holds until the next read. A read in the same cycle as a write returns the value from before that write.
- R8: When `fetch_en` is high, `fetch_word` shows the full word of slot `fetch_idx` in the next cycle. When `fetch_en` is low, `fetch_word` holds its value.
- R9: If a fetch and a data write target the same slot in the same cycle, the fetch returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | Register address: 0 = select, 1 = data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| fetch_en | input | 1 | Whole-word fetch request |
| fetch_idx | input | 3 | Slot to fetch |
| fetch_word | output | 257 | Fetched word, valid the cycle after the request |

## Verification
The bench goes after these corner cases:
- **Clipped lane 8.** A design that writes a full lane there would wrap or lose bits. A design that reads it without clipping would leak stale upper bits.
- **Lanes 9 to 15.** A design that decodes only the low bits of the lane number would alias these lanes onto real ones and corrupt a slot.
- **Fetch in the same cycle as a write to the same slot.** This catches a design that forwards the new data to the fetch.
- **Reads of the select register.** These expose reserved bits that were stored instead of cleared.
- **Each output between strobes.** This shows any output that fails to hold.

// File: rtl/ucw_pkg.sv
package ucw_pkg;
  localparam int UCW_SLOTS   = 8;
  localparam int UCW_WORD_W  = 257;
  localparam int UCW_DATA_W  = 32;
  localparam int UCW_SLOT_W  = 3;
  localparam int UCW_POS_W   = 4;

  typedef enum logic {
    UCW_REG_SEL  = 1'b0,
    UCW_REG_DATA = 1'b1
  } ucw_reg_e;
endpackage

// File: rtl/ucw_sel_reg.sv
module ucw_sel_reg #(
  parameter int SLOT_W = 3,
  parameter int POS_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [SLOT_W-1:0] slot,
  output logic [POS_W-1:0]  pos,
  output logic [DATA_W-1:0] rd_val
);
  localparam int FIELD_W = SLOT_W + POS_W;

  logic [FIELD_W-1:0] field_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     field_q <= '0;
    else if (wr_en) field_q <= wdata[FIELD_W-1:0];
  end

  assign slot   = field_q[SLOT_W-1:0];
  assign pos    = field_q[FIELD_W-1:SLOT_W];
  // Bits above the fields are not stored and read as zero.
  assign rd_val = DATA_W'(field_q);
endmodule

// File: rtl/ucw_slice_map.sv
module ucw_slice_map #(
  parameter int WORD_W = 257,
  parameter int DATA_W = 32,
  parameter int POS_W  = 4
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [POS_W-1:0]  pos,
  input  logic [DATA_W-1:0] wdata,
  output logic              pos_ok,
  output logic [WORD_W-1:0] word_merged,
  output logic [DATA_W-1:0] rd_slice
);
  localparam int NCHUNK = (WORD_W + DATA_W - 1) / DATA_W;
  localparam int SPAN   = NCHUNK * DATA_W;

  // Ones under the lane; the part that falls past WORD_W is cut off later.
  function automatic logic [SPAN-1:0] lane_mask(input int shamt);
    logic [SPAN-1:0] m;
    m = SPAN'({DATA_W{1'b1}});
    return m << shamt;
  endfunction

  function automatic logic [SPAN-1:0] lane_place(input logic [DATA_W-1:0] d, input int shamt);
    return SPAN'(d) << shamt;
  endfunction

  int unsigned     shamt;
  logic [SPAN-1:0] mask_w, data_w, word_w, merged_w, down_w;

  assign pos_ok = (int'(pos) < NCHUNK);
  assign shamt  = int'(pos) * DATA_W;

  always_comb begin
    word_w      = SPAN'(word_in);
    mask_w      = pos_ok ? lane_mask(shamt) : '0;
    data_w      = lane_place(wdata, shamt);
    merged_w    = (word_w & ~mask_w) | (data_w & mask_w);
    word_merged = merged_w[WORD_W-1:0];
    down_w      = word_w >> shamt;
    rd_slice    = pos_ok ? down_w[DATA_W-1:0] : '0;
  end
endmodule

// File: rtl/ucw_store.sv
module ucw_store #(
  parameter int SLOTS  = 8,
  parameter int WORD_W = 257,
  parameter int SLOT_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SLOT_W-1:0]       wr_slot,
  input  logic [WORD_W-1:0]       wr_word,
  input  logic [SLOT_W-1:0]       rd_slot,
  output logic [WORD_W-1:0]       rd_word,
  input  logic                    fetch_en,
  input  logic [SLOT_W-1:0]       fetch_idx,
  output logic [WORD_W-1:0]       fetch_word,
  output logic [SLOTS*WORD_W-1:0] mem_flat
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [WORD_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      slot_q <= '0;
      else if (wr_en && (int'(wr_slot) == g))          slot_q <= wr_word;
    end
    assign mem_flat[g*WORD_W +: WORD_W] = slot_q;
  end

  assign rd_word = mem_flat[int'(rd_slot)*WORD_W +: WORD_W];

  // The fetch reads the contents from before this edge, so a write in the same cycle is not seen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fetch_word <= '0;
    else if (fetch_en) fetch_word <= mem_flat[int'(fetch_idx)*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/ucode_window.sv
module ucode_window
  import ucw_pkg::*;
#(
  parameter int SLOTS  = UCW_SLOTS,
  parameter int WORD_W = UCW_WORD_W,
  parameter int DATA_W = UCW_DATA_W,
  parameter int SLOT_W = UCW_SLOT_W,
  parameter int POS_W  = UCW_POS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              fetch_en,
  input  logic [SLOT_W-1:0] fetch_idx,
  output logic [WORD_W-1:0] fetch_word
);
  logic [SLOT_W-1:0]       sel_slot;
  logic [POS_W-1:0]        sel_pos;
  logic [DATA_W-1:0]       sel_rd_val;
  logic [WORD_W-1:0]       cur_word, new_word;
  logic [DATA_W-1:0]       lane_rd;
  logic                    pos_ok;
  logic                    sel_wr, data_wr;
  logic [SLOTS*WORD_W-1:0] mem_flat;

  assign sel_wr  = reg_wr && (ucw_reg_e'(reg_addr) == UCW_REG_SEL);
  assign data_wr = reg_wr && (ucw_reg_e'(reg_addr) == UCW_REG_DATA) && pos_ok;

  ucw_sel_reg #(.SLOT_W(SLOT_W), .POS_W(POS_W), .DATA_W(DATA_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(sel_wr), .wdata(reg_wdata),
    .slot(sel_slot), .pos(sel_pos), .rd_val(sel_rd_val)
  );

  ucw_slice_map #(.WORD_W(WORD_W), .DATA_W(DATA_W), .POS_W(POS_W)) u_map (
    .word_in(cur_word), .pos(sel_pos), .wdata(reg_wdata),
    .pos_ok(pos_ok), .word_merged(new_word), .rd_slice(lane_rd)
  );

  ucw_store #(.SLOTS(SLOTS), .WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .wr_slot(sel_slot), .wr_word(new_word),
    .rd_slot(sel_slot), .rd_word(cur_word), .fetch_en(fetch_en), .fetch_idx(fetch_idx),
    .fetch_word(fetch_word), .mem_flat(mem_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= (ucw_reg_e'(reg_addr) == UCW_REG_DATA) ? lane_rd : sel_rd_val;
  end
endmodule

// File: rtl/ucw_checker.sv
module ucw_checker #(
  parameter int SLOTS  = ucw_pkg::UCW_SLOTS,
  parameter int WORD_W = ucw_pkg::UCW_WORD_W,
  parameter int DATA_W = ucw_pkg::UCW_DATA_W,
  parameter int SLOT_W = ucw_pkg::UCW_SLOT_W,
  parameter int POS_W  = ucw_pkg::UCW_POS_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_wr,
  input logic                    reg_rd,
  input logic                    reg_addr,
  input logic [DATA_W-1:0]       reg_rdata,
  input logic                    fetch_en,
  input logic [SLOT_W-1:0]       fetch_idx,
  input logic [WORD_W-1:0]       fetch_word,
  input logic [POS_W-1:0]        sel_pos,
  input logic [SLOTS*WORD_W-1:0] mem_flat
);
  localparam int NCHUNK = (WORD_W + DATA_W - 1) / DATA_W;
  localparam int TAIL_W = WORD_W - (NCHUNK - 1) * DATA_W;

  logic [WORD_W-1:0] fetch_pick;
  logic              bad_lane, tail_lane;
  assign fetch_pick = mem_flat[int'(fetch_idx)*WORD_W +: WORD_W];
  assign bad_lane   = (int'(sel_pos) >= NCHUNK);
  assign tail_lane  = (int'(sel_pos) == NCHUNK - 1);

  a_r2_sel_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_addr) |=> ((reg_rdata >> (SLOT_W + POS_W)) == '0));

  a_r4_tail_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && tail_lane) |=> ($countones(mem_flat ^ $past(mem_flat)) <= TAIL_W));

  a_r5_dead_lane_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && bad_lane) |=> $stable(mem_flat));

  a_r5_dead_lane_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr && bad_lane) |=> (reg_rdata == '0));

  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

  // R8 and R9: the fetch returns the slot as it was before the edge.
  a_r8_fetch_value: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |=> (fetch_word == $past(fetch_pick)));

  a_r8_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en |=> $stable(fetch_word));
endmodule

bind ucode_window ucw_checker #(
  .SLOTS(SLOTS), .WORD_W(WORD_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W), .POS_W(POS_W)
) u_chk (.*);

// File: tb/ucode_window_tb.sv
module ucode_window_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         fetch_en = 1'b0;
  logic [2:0]   fetch_idx = '0;
  logic [256:0] fetch_word;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  ucode_window u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_en(fetch_en),
    .fetch_idx(fetch_idx), .fetch_word(fetch_word)
  );

  // Reference model: bit-by-bit arithmetic on an unpacked store.
  logic [256:0] m_store [8];
  logic [2:0]   m_slot;
  logic [3:0]   m_pos;
  logic [31:0]  e_rdata;
  logic [256:0] e_fetch;
  string        rtag, ftag;
  bit           touched;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_store[i]) m_store[i] = '0;
      m_slot = '0; m_pos = '0; e_rdata = '0; e_fetch = '0;
      rtag = "R1"; ftag = "R1"; touched = 0;
    end else begin
      if (fetch_en) begin
        e_fetch = m_store[fetch_idx];
        if (reg_wr && reg_addr && m_slot == fetch_idx && m_pos < 9) ftag = "R9";
        else if (!touched) ftag = "R1 R8";
        else ftag = "R8";
      end
      if (reg_rd) begin
        if (!reg_addr) begin
          e_rdata = {25'b0, m_pos, m_slot};
          rtag = "R2 R7";
        end else begin
          e_rdata = '0;
          for (int b = 0; b < 32; b++)
            if (int'(m_pos)*32 + b < 257) e_rdata[b] = m_store[m_slot][int'(m_pos)*32 + b];
          rtag = (m_pos < 8) ? "R3 R6 R7" : (m_pos == 8) ? "R4 R7" : "R5 R7";
        end
      end
      if (reg_wr) begin
        if (!reg_addr) {m_pos, m_slot} = reg_wdata[6:0];
        else begin
          for (int b = 0; b < 32; b++)
            if (int'(m_pos)*32 + b < 257) m_store[m_slot][int'(m_pos)*32 + b] = reg_wdata[b];
          touched = 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [256:0] act, input logic [256:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rtag, 257'(reg_rdata), 257'(e_rdata));
      chk(ftag, fetch_word, e_fetch);
    end
  end

  task automatic cyc(input logic wr, input logic rd, input logic ad, input logic [31:0] wd,
                     input logic fe, input logic [2:0] fi);
    reg_wr = wr; reg_rd = rd; reg_addr = ad; reg_wdata = wd; fetch_en = fe; fetch_idx = fi;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state through both read paths
    chk("R1", 257'(reg_rdata), '0);
    chk("R1", fetch_word, '0);
    cyc(0, 1, 0, 0, 0, 0);
    for (int s = 0; s < 8; s++) cyc(0, 0, 0, 0, 1, 3'(s));
    // R2: reserved select bits dropped
    cyc(1, 0, 0, 32'hFFFF_FFFF, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);
    // R5: lane 15 of slot 7 is dead
    cyc(1, 0, 1, 32'hDEAD_BEEF, 0, 0);
    cyc(0, 1, 1, 0, 1, 7);
    cyc(1, 0, 0, 32'h0000_0049, 0, 0);   // lane 9, slot 1
    cyc(1, 0, 1, 32'hFFFF_FFFF, 0, 0);
    cyc(0, 1, 1, 0, 1, 1);
    // R3, R4, R9: fill every lane with a fetch of the same slot in the write cycle
    for (int s = 0; s < 8; s++)
      for (int p = 0; p < 9; p++) begin
        cyc(1, 0, 0, 32'((p << 3) | s), 0, 0);
        cyc(1, 0, 1, 32'h9E37_79B9 * 32'(s*9 + p + 1), 1, 3'(s));
        cyc(0, 0, 0, 0, 1, 3'(s));
      end
    // R6: read back every lane
    for (int s = 0; s < 8; s++)
      for (int p = 0; p < 11; p++) begin
        cyc(1, 0, 0, 32'((p << 3) | s), 0, 0);
        cyc(0, 1, 1, 0, 0, 0);
      end
    // Mixed traffic, lanes 8 to 15 included
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0] & ~r[1], r[1], r[2], (r[3] ? $urandom : 32'($urandom_range(0, 127))), r[4], r[7:5]);
    end
    cyc(0, 0, 0, 0, 0, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule